// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between a small group of cores and a shared word-addressed register-file memory. It keeps one address reservation per core. A load-linked request reads a word and arms that core's reservation on the word. A store-conditional then writes only if no other write has reached the reserved word in the meantime. The core gets the outcome back as a single pass flag and retries when the flag is clear. Plain loads and stores go through the same path, and every write that completes on the shared bus is compared against all armed reservations.

The cores share one bus and one operation is granted per cycle. Grants go by fixed priority, lowest core index first. A store-conditional whose reservation has already been lost, or is aimed at another word, never asks for the bus. It is acknowledged at once as a failure, with no memory write and no bus write strobe. When several cores hold a reservation on the same word and issue store-conditionals in the same cycle, only the bus winner passes. Its write clears the other reservations, so the losers fail on their next cycle.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset no reservation is armed, every memory word reads 0, and `resp_valid` and `bus_wr_valid` are 0. A store-conditional issued before any load-linked fails.
- R2: A load or load-linked returns the current word on `resp_rdata` in the cycle after its acknowledge. A load-linked also arms the issuing core's reservation on that word address.
- R3: A store-conditional to the reserved word with no write to that word since the load-linked passes. It returns `resp_pass`=1, puts the write on the bus, and updates memory.
- R4: A completed write by any core to a word clears every reservation on that word, so a later store-conditional to it fails and memory keeps the intervening value.
- R5: A failing store-conditional is acknowledged in the cycle it is presented, whatever the other cores request. It produces no bus write strobe and changes no memory word.
- R6: When two cores hold reservations on one word and issue store-conditionals in the same cycle, exactly one passes: the lower core index. Memory then holds that core's data.
- R7: A new load-linked from a core replaces that core's earlier reservation.
- R8: Every store-conditional, pass or fail, disarms the issuing core's own reservation, so a second one without a new load-linked fails.
- R9: Reservations are per word address. A write to a neighbouring word leaves the reservation armed.
- R10: Bus requests are granted one per cycle by fixed priority, lowest index first. Each acknowledge is followed exactly one cycle later by `resp_valid` for that core. A core's request stays unacknowledged while a lower-index core uses the bus.
- R11: A store-conditional to a word other than the one reserved fails.
- R12: Operation encoding on `req_op`: 0 load, 1 store, 2 load-linked, 3 store-conditional. `resp_pass` is 1 only for a passing store-conditional, and `resp_rdata` is 0 for stores and store-conditionals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NC | Per-core request, held until acknowledged |
| req_op | input | 2*NC | Per-core operation code, 2 bits per core |
| req_addr | input | AW*NC | Per-core word address |
| req_wdata | input | DW*NC | Per-core write data |
| req_ack | output | NC | Request accepted this cycle (granted or failed early) |
| resp_valid | output | NC | Result available, one cycle after acknowledge |
| resp_pass | output | NC | Store-conditional passed |
| resp_rdata | output | DW*NC | Read data for load and load-linked |
| bus_wr_valid | output | 1 | A write is on the shared bus this cycle |
| bus_wr_addr | output | AW | Word address of the bus write |
| bus_owner | output | max(1,clog2(NC)) | Index of the core holding the bus |

## Verification
The embedded properties check every cycle that at most one grant and at most one store-conditional pass occur, and that each pass was preceded by that core's own bus write. They also check that a failed store-conditional had no bus write, that every response follows an acknowledge, and that a reservation arms only from a granted load-linked. Whether the data, the pass/fail decisions and the reservation-clearing rules are actually right cannot be seen from such local relations. The bench shows these through directed sequences (intervening stores, replaced reservations, neighbour-word writes, same-cycle competing store-conditionals) and through a randomised mix compared each clock against a behavioural model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } llsc_op_e;

    // Operations that put a write on the shared bus when granted
    function automatic logic op_writes(llsc_op_e op);
        return (op == OP_STORE) || (op == OP_SC);
    endfunction

    // Operations that return read data
    function automatic logic op_reads(llsc_op_e op);
        return (op == OP_LOAD) || (op == OP_LL);
    endfunction

    typedef struct packed {
        logic     granted;
        llsc_op_e op;
    } bus_cmd_t;

endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] req,
    output logic [NC-1:0] grant
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NC; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R10
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/llsc_resv_bank.sv
module llsc_resv_bank #(
    parameter int NC = 4,
    parameter int AW = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NC-1:0]          ll_set,
    input  logic [AW-1:0]          ll_addr,
    input  logic [NC-1:0]          own_clr,
    input  logic                   snoop_wr,
    input  logic [AW-1:0]          snoop_addr,
    output logic [NC-1:0]          resv_valid,
    output logic [NC-1:0][AW-1:0]  resv_addr
);

    for (genvar g = 0; g < NC; g++) begin : g_slot
        logic hit;
        assign hit = snoop_wr && (resv_addr[g] == snoop_addr);

        always_ff @(posedge clk) begin
            if (rst) begin
                resv_valid[g] <= 1'b0;
                resv_addr[g]  <= '0;
            end else if (ll_set[g]) begin
                resv_valid[g] <= 1'b1;
                resv_addr[g]  <= ll_addr;
            end else if (own_clr[g] || hit) begin
                resv_valid[g] <= 1'b0;
            end
        end

        // R2
        arm_from_ll_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(resv_valid[g]) |-> $past(ll_set[g]));

        // R4
        snoop_kill_chk: assert property (@(posedge clk) disable iff (rst)
            (snoop_wr && !ll_set[g] && resv_valid[g] && resv_addr[g] == snoop_addr)
            |=> !resv_valid[g]);
    end

endmodule

// File: rtl/llsc_regfile.sv
module llsc_regfile #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NC = 4,
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int IW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NC-1:0]    req_valid,
    input  logic [2*NC-1:0]  req_op,
    input  logic [AW*NC-1:0] req_addr,
    input  logic [DW*NC-1:0] req_wdata,
    output logic [NC-1:0]    req_ack,
    output logic [NC-1:0]    resp_valid,
    output logic [NC-1:0]    resp_pass,
    output logic [DW*NC-1:0] resp_rdata,
    output logic             bus_wr_valid,
    output logic [AW-1:0]    bus_wr_addr,
    output logic [IW-1:0]    bus_owner
);

    llsc_op_e              op_v   [NC];
    logic [AW-1:0]         addr_v [NC];
    logic [NC-1:0]         is_sc, is_ll, sc_ok, need_bus, early_fail, grant;
    logic [NC-1:0]         resv_valid;
    logic [NC-1:0][AW-1:0] resv_addr;
    logic [DW-1:0]         sel_wdata, rd_data;
    bus_cmd_t              cmd;

    for (genvar g = 0; g < NC; g++) begin : g_dec
        assign op_v[g]       = llsc_op_e'(req_op[2*g +: 2]);
        assign addr_v[g]     = req_addr[AW*g +: AW];
        assign is_sc[g]      = (op_v[g] == OP_SC);
        assign is_ll[g]      = (op_v[g] == OP_LL);
        assign sc_ok[g]      = resv_valid[g] && (resv_addr[g] == addr_v[g]);
        assign need_bus[g]   = req_valid[g] && (!is_sc[g] || sc_ok[g]);
        assign early_fail[g] = req_valid[g] && is_sc[g] && !sc_ok[g];
    end

    llsc_arb #(.NC(NC)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (need_bus),
        .grant (grant)
    );

    always_comb begin
        cmd         = '{granted: 1'b0, op: OP_LOAD};
        bus_wr_addr = '0;
        sel_wdata   = '0;
        bus_owner   = '0;
        for (int i = 0; i < NC; i++) begin
            if (grant[i]) begin
                cmd.granted = 1'b1;
                cmd.op      = op_v[i];
                bus_wr_addr = addr_v[i];
                sel_wdata   = req_wdata[DW*i +: DW];
                bus_owner   = IW'(i);
            end
        end
    end

    assign bus_wr_valid = cmd.granted && op_writes(cmd.op);
    assign req_ack      = grant | early_fail;

    llsc_resv_bank #(.NC(NC), .AW(AW)) u_resv (
        .clk        (clk),
        .rst        (rst),
        .ll_set     (grant & is_ll),
        .ll_addr    (bus_wr_addr),
        .own_clr    (early_fail | (grant & is_sc)),
        .snoop_wr   (bus_wr_valid),
        .snoop_addr (bus_wr_addr),
        .resv_valid (resv_valid),
        .resv_addr  (resv_addr)
    );

    llsc_regfile #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_wr_valid),
        .waddr (bus_wr_addr),
        .wdata (sel_wdata),
        .raddr (bus_wr_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= '0;
            resp_pass  <= '0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_ack;
            resp_pass  <= grant & is_sc;
            for (int i = 0; i < NC; i++) begin
                resp_rdata[DW*i +: DW] <= (grant[i] && op_reads(op_v[i])) ? rd_data : '0;
            end
        end
    end

    // R6
    one_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(resp_pass) <= 1);

    for (genvar g = 0; g < NC; g++) begin : g_chk
        // R3
        pass_owned_bus_chk: assert property (@(posedge clk) disable iff (rst)
            resp_pass[g] |-> ($past(bus_wr_valid) && $past(bus_owner) == IW'(g)));

        // R5
        fail_silent_chk: assert property (@(posedge clk) disable iff (rst)
            (early_fail[g] && !rst) |=> !resp_pass[g] && !$past(bus_wr_valid && bus_owner == IW'(g)));

        // R10
        resp_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
            resp_valid[g] |-> $past(req_ack[g]));
    end

endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;

    localparam int NC = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NC-1:0]    req_valid = '0;
    logic [2*NC-1:0]  req_op = '0;
    logic [AW*NC-1:0] req_addr = '0;
    logic [DW*NC-1:0] req_wdata = '0;
    logic [NC-1:0]    req_ack, resp_valid, resp_pass;
    logic [DW*NC-1:0] resp_rdata;
    logic             bus_wr_valid;
    logic [AW-1:0]    bus_wr_addr;
    logic [IW-1:0]    bus_owner;

    llsc_monitor #(.NC(NC), .AW(AW), .DW(DW)) u0 (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // pending requests per core
    bit          pv [NC];
    int          pop [NC];
    int          pad [NC];
    logic [31:0] pdt [NC];

    // reference model
    bit          m_rv [NC];
    int          m_ra [NC];
    logic [31:0] m_mem [256];
    bit          e_rv [NC];
    bit          e_pass [NC];
    logic [31:0] e_data [NC];

    // captured DUT results
    bit          last_pass [NC];
    logic [31:0] last_data [NC];
    int          ack_step [NC];
    int          stepno = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        int g;
        bit ef [NC];
        bit ack_e [NC];
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            req_valid[i]         = pv[i];
            req_op[2*i +: 2]     = pop[i][1:0];
            req_addr[AW*i +: AW] = pad[i][AW-1:0];
            req_wdata[DW*i +: DW]= pdt[i];
        end
        #2;
        g = -1;
        for (int i = 0; i < NC; i++) begin
            ef[i] = 1'b0;
            if (pv[i]) begin
                if (pop[i] == 3 && !(m_rv[i] && m_ra[i] == pad[i])) ef[i] = 1'b1;
                else if (g < 0) g = i;
            end
        end
        for (int i = 0; i < NC; i++) begin
            ack_e[i] = ef[i] || (g == i);
            // R10 acknowledge pattern
            chk(req_ack[i] == ack_e[i], "R10 ack", req_ack[i], ack_e[i]);
            if (req_ack[i]) ack_step[i] = stepno;
        end
        // R5 bus write only for granted store / passing store-conditional
        chk(bus_wr_valid == (g >= 0 && (pop[g] == 1 || pop[g] == 3)), "R5 bus_wr",
            bus_wr_valid, (g >= 0 && (pop[g] == 1 || pop[g] == 3)));
        if (bus_wr_valid && g >= 0)
            chk(bus_wr_addr == pad[g][AW-1:0], "R5 bus_addr", bus_wr_addr, pad[g]);
        for (int i = 0; i < NC; i++) begin
            e_rv[i]   = ack_e[i];
            e_pass[i] = (g == i) && pop[i] == 3;
            e_data[i] = ((g == i) && (pop[i] == 0 || pop[i] == 2)) ? m_mem[pad[i]] : 32'h0;
            if (ef[i]) m_rv[i] = 1'b0;
        end
        if (g >= 0) begin
            if (pop[g] == 2) begin
                m_rv[g] = 1'b1;
                m_ra[g] = pad[g];
            end else if (pop[g] == 1 || pop[g] == 3) begin
                m_mem[pad[g]] = pdt[g];
                for (int j = 0; j < NC; j++)
                    if (m_rv[j] && m_ra[j] == pad[g]) m_rv[j] = 1'b0;
                if (pop[g] == 3) m_rv[g] = 1'b0;
            end
        end
        for (int i = 0; i < NC; i++) if (ack_e[i]) pv[i] = 1'b0;
        @(posedge clk);
        #2;
        stepno++;
        for (int i = 0; i < NC; i++) begin
            chk(resp_valid[i] == e_rv[i], "R10 resp_valid", resp_valid[i], e_rv[i]);
            chk(resp_pass[i] == e_pass[i], "R12 resp_pass", resp_pass[i], e_pass[i]);
            chk(resp_rdata[DW*i +: DW] == e_data[i], "R2 resp_rdata",
                resp_rdata[DW*i +: DW], e_data[i]);
            if (resp_valid[i]) begin
                last_pass[i] = resp_pass[i];
                last_data[i] = resp_rdata[DW*i +: DW];
            end
        end
    endtask

    task automatic issue(int c, int op, int a, logic [31:0] d);
        pv[c] = 1'b1; pop[c] = op; pad[c] = a; pdt[c] = d;
    endtask

    task automatic drain();
        for (int k = 0; k < 40; k++) begin
            bit busy;
            busy = 1'b0;
            for (int i = 0; i < NC; i++) busy |= pv[i];
            if (!busy) break;
            step();
        end
    endtask

    task automatic op1(int c, int op, int a, logic [31:0] d);
        issue(c, op, a, d);
        drain();
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            pv[i] = 0; pop[i] = 0; pad[i] = 0; pdt[i] = 0;
            m_rv[i] = 0; m_ra[i] = 0; last_pass[i] = 0; last_data[i] = 0; ack_step[i] = 0;
        end
        for (int i = 0; i < 256; i++) m_mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk(resp_valid == '0, "R1 resp_valid", resp_valid, 0);
        chk(bus_wr_valid == 1'b0, "R1 bus_wr", bus_wr_valid, 0);
        op1(0, 3, 7, 32'h1);
        chk(last_pass[0] == 0, "R1 sc before ll", last_pass[0], 0);
        op1(2, 0, 7, 0);
        chk(last_data[2] == 0, "R1 mem cleared", last_data[2], 0);

        // R2 load-linked returns data
        op1(1, 1, 5, 32'hA5);
        op1(0, 2, 5, 0);
        chk(last_data[0] == 32'hA5, "R2 ll data", last_data[0], 32'hA5);

        // R3 clean store-conditional passes
        op1(0, 3, 5, 32'h11);
        chk(last_pass[0] == 1, "R3 sc pass", last_pass[0], 1);
        op1(2, 0, 5, 0);
        chk(last_data[2] == 32'h11, "R3 mem written", last_data[2], 32'h11);

        // R4 intervening store kills reservation
        op1(0, 2, 10, 0);
        op1(1, 1, 10, 32'h22);
        op1(0, 3, 10, 32'h33);
        chk(last_pass[0] == 0, "R4 sc fail", last_pass[0], 0);
        op1(3, 0, 10, 0);
        chk(last_data[3] == 32'h22, "R4 mem kept", last_data[3], 32'h22);

        // R5 early fail acknowledged while bus is used by a higher-priority core
        op1(3, 2, 16, 0);
        op1(0, 1, 16, 32'h44);
        issue(0, 0, 16, 0);
        issue(3, 3, 16, 32'h55);
        step();
        chk(pv[3] == 0, "R5 early ack", pv[3], 0);
        chk(last_pass[3] == 0, "R5 sc fail", last_pass[3], 0);
        drain();
        op1(1, 0, 16, 0);
        chk(last_data[1] == 32'h44, "R5 no write", last_data[1], 32'h44);

        // R6 same-cycle competing store-conditionals
        op1(1, 2, 20, 0);
        op1(2, 2, 20, 0);
        issue(1, 3, 20, 32'h66);
        issue(2, 3, 20, 32'h77);
        drain();
        chk(last_pass[1] == 1, "R6 winner", last_pass[1], 1);
        chk(last_pass[2] == 0, "R6 loser", last_pass[2], 0);
        op1(0, 0, 20, 0);
        chk(last_data[0] == 32'h66, "R6 mem", last_data[0], 32'h66);

        // R7 new load-linked replaces old reservation
        op1(0, 2, 25, 0);
        op1(0, 2, 26, 0);
        op1(0, 3, 25, 32'h88);
        chk(last_pass[0] == 0, "R7 old resv", last_pass[0], 0);

        // R8 store-conditional disarms own reservation
        op1(2, 2, 30, 0);
        op1(2, 3, 30, 32'h99);
        chk(last_pass[2] == 1, "R8 first sc", last_pass[2], 1);
        op1(2, 3, 30, 32'h9A);
        chk(last_pass[2] == 0, "R8 second sc", last_pass[2], 0);

        // R9 neighbour word leaves reservation
        op1(0, 2, 40, 0);
        op1(1, 1, 41, 32'hBB);
        op1(0, 3, 40, 32'hCC);
        chk(last_pass[0] == 1, "R9 neighbour", last_pass[0], 1);

        // R10 priority order
        for (int i = 0; i < NC; i++) issue(i, 0, 50 + i, 0);
        drain();
        for (int i = 1; i < NC; i++)
            chk(ack_step[i] == ack_step[i-1] + 1, "R10 order", ack_step[i], ack_step[i-1] + 1);

        // R11 other-word store-conditional fails
        op1(3, 2, 60, 0);
        op1(3, 3, 61, 32'hDD);
        chk(last_pass[3] == 0, "R11 wrong word", last_pass[3], 0);

        // R12 random mix against model
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < NC; i++)
                if (!pv[i] && ($urandom % 2 == 0))
                    issue(i, int'($urandom % 4), 100 + int'($urandom % 3), $urandom);
            step();
        end
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule